// File: doc/BRIEF.md
# Cascaded Master Serial Configuration Loader

This block is the configuration engine of the first device in a two-device serial configuration chain. When its mode pins select master serial operation, it starts by itself once reset is released. It pulses the serial memory's reset/output-enable low so that the memory's address counter restarts, and clears its own configuration shift store. It then drives a divided configuration clock and captures one serial data bit on every rising edge of that clock, until its own image of `IMG_BITS` bits is complete.

After the local load, the engine raises its done output and then, one cycle later, its chip-select output to the downstream device. The serial stream is the local image followed directly by the downstream image. The engine keeps clocking the downstream device and does not store those later bits. Clocking stops when the shared, wired completion line reads high. If the line stays low too long, a watchdog raises a fault and stops the clock. A user reload request returns a finished or faulted engine to its idle state, and a new pass then starts.

When the mode pins select slave serial operation, the engine drives no clock and no memory reset. It captures a bit on each rising edge of an externally supplied clock while its select input is high. Every other mode code leaves the engine idle. The states are IDLE, MEMRST, LOAD, HANDOFF, DONE, FAULT, SLAVE and SLVDONE. The transitions are:
- IDLE to MEMRST on master code.
- IDLE to SLAVE on a slave code.
- MEMRST to LOAD after the pulse.
- LOAD to HANDOFF when the store is full.
- HANDOFF to DONE when the completion line is high.
- HANDOFF to FAULT when the watchdog expires.
- SLAVE to SLVDONE when the store is full.
- DONE, FAULT or SLVDONE to IDLE on a reload request.

Top module: `cascade_cfg_loader`

## Requirements
- R1: Mode code 000 (`mode_sel[2:0]`) selects master serial. In IDLE the engine then moves on by itself to a memory reset pulse, with no request needed.
- R2: Each master pass begins with `mem_rst_n` low for exactly `MEMRST_CYC` consecutive cycles. During these cycles `cfg_clk` is low and `own_done` is low, because the store has been cleared.
- R3: In LOAD and HANDOFF, `cfg_clk` has a period of `CLK_DIV` clock cycles and is high for `CLK_DIV/2` of them. The first rise comes `CLK_DIV/2` cycles after LOAD is entered.
- R4: `cfg_din` is captured on the clock edge at which `cfg_clk` rises. Bits are shifted in at bit 0, so the first bit of the stream ends in the MSB of `cfg_image`. `own_done` goes high on the edge that captures bit `IMG_BITS`.
- R5: `cs_out` rises one cycle after `own_done` rises and is only ever high while `own_done` is high.
- R6: Bits after the first `IMG_BITS` do not change `cfg_image`.
- R7: While `cs_out` is high and `chain_done` is low, `cfg_clk` keeps toggling. Once `chain_done` is sampled high, `cfg_clk` produces no further rising edge.
- R8: If `chain_done` stays low for `WDOG_CYC` cycles in HANDOFF, `wdog_fault` goes high, `cs_out` drops and `cfg_clk` stays low.
- R9: A one-cycle `reload_req` in DONE or FAULT starts a complete new pass with a fresh memory reset pulse. `reload_req` during LOAD is ignored.
- R10: Codes 001 and 111 select slave serial. In slave serial, `cfg_clk`, `mem_rst_n` and `cs_out` stay inactive, and a bit is captured on each rising edge of `ext_cclk` seen while `sel_in` is high. Edges seen while `sel_in` is low are ignored.
- R11: Any other mode code leaves the engine in IDLE, with no clock, no memory reset, no capture and no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Configuration mode code, read in IDLE |
| cfg_din | input | 1 | Serial configuration data |
| reload_req | input | 1 | User request for a new configuration pass |
| chain_done | input | 1 | Shared wired completion line, high when the chain has finished |
| ext_cclk | input | 1 | External configuration clock used in slave serial mode |
| sel_in | input | 1 | Chip select from upstream, used in slave serial mode |
| cfg_clk | output | 1 | Generated configuration clock for the memory and downstream device |
| mem_rst_n | output | 1 | Active-low reset/output-enable pulse to the serial memory |
| cs_out | output | 1 | Chip select to the downstream device |
| own_done | output | 1 | Local image fully loaded |
| wdog_fault | output | 1 | Completion line timed out |
| cfg_image | output | IMG_BITS | Captured local configuration image |

## Verification
The assertions take for granted four things about the inputs:
- `mode_sel` changes only while the engine is held in reset.
- `ext_cclk` and `sel_in` are synchronous to `clk` and stay stable for at least one cycle between changes.
- `chain_done` rises only after `cs_out` has risen.
- `reload_req` lasts a single cycle.

The stimulus applies every input change half a cycle away from the active edge. It changes the mode only with reset asserted, and drives the external clock in three-cycle bit slots. A bench model of the serial memory and of a downstream device supplies data and the completion line in response to the design's own clock and chip select.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MEMRST,
        ST_LOAD,
        ST_HANDOFF,
        ST_DONE,
        ST_FAULT,
        ST_SLAVE,
        ST_SLVDONE
    } ld_state_e;

    typedef enum logic [1:0] {
        MD_MASTER,
        MD_SLAVE,
        MD_NONE
    } md_kind_e;

    // master serial drives the clock; two codes select slave serial
    function automatic md_kind_e decode_mode(input logic [2:0] code);
        md_kind_e kind;
        case (code)
            3'b000:         kind = MD_MASTER;
            3'b001, 3'b111: kind = MD_SLAVE;
            default:        kind = MD_NONE;
        endcase
        return kind;
    endfunction

endpackage

// File: rtl/cfg_clkgen.sv
module cfg_clkgen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic cclk,
    output logic rise_tick
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CW-1:0] div_cnt;
    logic          cclk_q;

    assign rise_tick = en && (div_cnt == CW'(HALF - 1));
    assign cclk      = cclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            cclk_q  <= 1'b0;
        end else if (!en) begin
            div_cnt <= '0;
            cclk_q  <= 1'b0;
        end else begin
            if (rise_tick)
                cclk_q <= 1'b1;
            else if (div_cnt == CW'(DIV - 1))
                cclk_q <= 1'b0;
            div_cnt <= (div_cnt == CW'(DIV - 1)) ? '0 : div_cnt + 1'b1;
        end
    end

    // R3: every rising edge comes from the half-period point of an enabled divider
    p_rise_from_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cclk_q) |-> ($past(div_cnt) == CW'(HALF - 1)) && $past(en));

    // R3: the divider never leaves its range
    p_div_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        div_cnt <= CW'(DIV - 1));

endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
    parameter int BITS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            tick,
    input  logic            din,
    output logic [BITS-1:0] image,
    output logic            full
);
    localparam int KW = $clog2(BITS + 1);

    logic [BITS-1:0] img_q;
    logic [KW-1:0]   count;

    assign full  = (count == KW'(BITS));
    assign image = img_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            img_q <= '0;
            count <= '0;
        end else if (clr) begin
            img_q <= '0;
            count <= '0;
        end else if (tick && !full) begin
            img_q <= (img_q << 1) | BITS'(din);
            count <= count + 1'b1;
        end
    end

    // R6: once full, the stored image is frozen until the next clear
    p_hold_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !clr) |=> $stable(img_q));

    // R4: the count never passes the image length
    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= KW'(BITS));

endmodule

// File: rtl/cfg_watchdog.sv
module cfg_watchdog #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int WW = $clog2(LIMIT + 1);

    logic [WW-1:0] cnt;

    assign expired = run && (cnt == WW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run)
            cnt <= '0;
        else if (!expired)
            cnt <= cnt + 1'b1;
    end

    // R8: the timeout counter stays inside its window
    p_wd_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < WW'(LIMIT));

endmodule

// File: rtl/cascade_cfg_loader.sv
module cascade_cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int IMG_BITS   = 16,
    parameter int CLK_DIV    = 4,
    parameter int MEMRST_CYC = 3,
    parameter int WDOG_CYC   = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          mode_sel,
    input  logic                cfg_din,
    input  logic                reload_req,
    input  logic                chain_done,
    input  logic                ext_cclk,
    input  logic                sel_in,
    output logic                cfg_clk,
    output logic                mem_rst_n,
    output logic                cs_out,
    output logic                own_done,
    output logic                wdog_fault,
    output logic [IMG_BITS-1:0] cfg_image
);
    localparam int RW = $clog2(MEMRST_CYC + 1);

    ld_state_e     state, state_nx;
    logic [RW-1:0] rst_cnt;
    logic          ext_q;
    logic          clk_run, store_clr, wd_run;
    logic          cclk_rise, slave_rise, shift_tick;
    logic          store_full, wd_expired;

    cfg_clkgen #(.DIV(CLK_DIV)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (clk_run),
        .cclk      (cfg_clk),
        .rise_tick (cclk_rise)
    );

    cfg_shifter #(.BITS(IMG_BITS)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (store_clr),
        .tick  (shift_tick),
        .din   (cfg_din),
        .image (cfg_image),
        .full  (store_full)
    );

    cfg_watchdog #(.LIMIT(WDOG_CYC)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (wd_run),
        .expired (wd_expired)
    );

    assign slave_rise = ext_cclk && !ext_q;
    assign shift_tick = cclk_rise || ((state == ST_SLAVE) && sel_in && slave_rise);
    assign own_done   = store_full;

    // state register and memory-reset pulse counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            rst_cnt <= '0;
            ext_q   <= 1'b0;
        end else begin
            state   <= state_nx;
            rst_cnt <= (state == ST_MEMRST) ? rst_cnt + 1'b1 : '0;
            ext_q   <= ext_cclk;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                case (decode_mode(mode_sel))
                    MD_MASTER: state_nx = ST_MEMRST;
                    MD_SLAVE:  state_nx = ST_SLAVE;
                    default:   state_nx = ST_IDLE;
                endcase
            end
            ST_MEMRST:  if (rst_cnt == RW'(MEMRST_CYC - 1)) state_nx = ST_LOAD;
            ST_LOAD:    if (store_full) state_nx = ST_HANDOFF;
            ST_HANDOFF: begin
                if (chain_done)      state_nx = ST_DONE;
                else if (wd_expired) state_nx = ST_FAULT;
            end
            ST_DONE, ST_FAULT, ST_SLVDONE: if (reload_req) state_nx = ST_IDLE;
            ST_SLAVE:   if (store_full) state_nx = ST_SLVDONE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // state-decoded outputs and controls
    always_comb begin
        mem_rst_n  = (state != ST_MEMRST);
        cs_out     = (state == ST_HANDOFF) || (state == ST_DONE);
        wdog_fault = (state == ST_FAULT);
        clk_run    = (state == ST_LOAD) || (state == ST_HANDOFF);
        store_clr  = (state == ST_IDLE) || (state == ST_MEMRST);
        wd_run     = (state == ST_HANDOFF);
    end

    // R5: chip select only while the local image is complete
    p_cs_needs_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_out |-> own_done);

    // R5: chip select rises after done was already high
    p_cs_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_out) |-> $past(own_done));

    // R2: no clock and no done during the memory reset pulse
    p_quiet_memrst_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rst_n |-> (!cfg_clk && !own_done));

    // R7: clock stops once the chain has completed
    p_stop_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |=> !cfg_clk);

    // R8: clock stops after a watchdog fault
    p_stop_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_fault |=> !cfg_clk);

    // R10: slave serial drives neither clock, memory reset nor chip select
    p_slave_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SLAVE) || (state == ST_SLVDONE)) |-> (!cfg_clk && !cs_out && mem_rst_n));

endmodule

// File: tb/cascade_cfg_loader_test.sv
module cascade_cfg_loader_test;
    localparam int CLK_PERIOD = 10;
    localparam int IMG  = 12;
    localparam int DIV  = 4;
    localparam int HALF = DIV / 2;
    localparam int RST  = 3;
    localparam int WD   = 80;
    localparam int SLV  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] mode_sel = 3'b000;
    logic reload_req = 1'b0;
    logic chain_done = 1'b0;
    logic ext_cclk = 1'b0;
    logic sel_in = 1'b0;
    logic mem_bit = 1'b0;
    logic slv_din = 1'b0;
    logic mem_drive = 1'b1;
    logic slave_ok = 1'b1;
    wire  cfg_din = mem_drive ? mem_bit : slv_din;

    logic cfg_clk, mem_rst_n, cs_out, own_done, wdog_fault;
    logic [IMG-1:0] cfg_image;

    cascade_cfg_loader #(.IMG_BITS(IMG), .CLK_DIV(DIV), .MEMRST_CYC(RST), .WDOG_CYC(WD)) uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cfg_din(cfg_din),
        .reload_req(reload_req), .chain_done(chain_done), .ext_cclk(ext_cclk),
        .sel_in(sel_in), .cfg_clk(cfg_clk), .mem_rst_n(mem_rst_n), .cs_out(cs_out),
        .own_done(own_done), .wdog_fault(wdog_fault), .cfg_image(cfg_image)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    logic mem [0:63];
    int addr = 0, slv_cnt = 0, n_rise = 0, n_mrst = 0;
    logic last_ck = 1'b0;

    // behavioural expectation: phase codes 0 idle,1 memrst,2 load,3 handoff,4 done,5 fault,6 slave,7 slave done
    int m_ph = 0, m_tmr = 0, m_dv = 0, m_nb = 0, m_wd = 0;
    logic m_ck = 1'b0, m_exq = 1'b0;
    logic [IMG-1:0] m_img = '0;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int nph;
        logic en, tick, clr, full, expw;
        if (!rst_n) begin
            m_ph = 0; m_tmr = 0; m_dv = 0; m_ck = 0; m_img = '0; m_nb = 0; m_wd = 0; m_exq = 0;
            return;
        end
        en   = (m_ph == 2) || (m_ph == 3);
        full = (m_nb == IMG);
        clr  = (m_ph == 0) || (m_ph == 1);
        tick = (en && m_dv == HALF - 1) || (m_ph == 6 && sel_in && ext_cclk && !m_exq);
        expw = (m_ph == 3) && (m_wd == WD - 1);
        nph  = m_ph;
        case (m_ph)
            0: if (mode_sel == 3'b000) nph = 1; else if (mode_sel == 3'b001 || mode_sel == 3'b111) nph = 6;
            1: if (m_tmr == RST - 1) nph = 2;
            2: if (full) nph = 2 + 1;
            3: if (chain_done) nph = 4; else if (expw) nph = 5;
            4, 5, 7: if (reload_req) nph = 0;
            6: if (full) nph = 7;
            default: nph = 0;
        endcase
        m_tmr = (m_ph == 1) ? m_tmr + 1 : 0;
        if (clr) begin m_img = '0; m_nb = 0; end
        else if (tick && !full) begin m_img = {m_img[IMG-2:0], cfg_din}; m_nb++; end
        if (en) begin
            if (m_dv == HALF - 1) m_ck = 1'b1; else if (m_dv == DIV - 1) m_ck = 1'b0;
            m_dv = (m_dv == DIV - 1) ? 0 : m_dv + 1;
        end else begin m_dv = 0; m_ck = 1'b0; end
        m_wd = (m_ph == 3) ? (expw ? m_wd : m_wd + 1) : 0;
        m_exq = ext_cclk;
        m_ph = nph;
    endtask

    // per-cycle model compare plus serial memory and downstream device emulation
    always @(negedge clk) begin
        logic rise_seen;
        model_step();
        chk("R3 cfg_clk", cfg_clk, m_ck);
        chk("R2 mem_rst_n", mem_rst_n, (m_ph != 1));
        chk("R5 cs_out", cs_out, (m_ph == 3 || m_ph == 4));
        chk("R4 own_done", own_done, (m_nb == IMG));
        chk("R8 wdog_fault", wdog_fault, (m_ph == 5));
        chk("R4 cfg_image", cfg_image, m_img);
        rise_seen = cfg_clk && !last_ck;
        last_ck = cfg_clk;
        if (!mem_rst_n) addr = 0; else if (rise_seen) addr++;
        mem_bit = (addr < 64) ? mem[addr] : 1'b0;
        if (!cs_out) slv_cnt = 0; else if (rise_seen) slv_cnt++;
        chain_done = slave_ok && cs_out && (slv_cnt >= SLV);
        if (rise_seen) n_rise++;
        if (!mem_rst_n) n_mrst++;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    function automatic logic [IMG-1:0] exp_image();
        logic [IMG-1:0] e = '0;
        for (int i = 0; i < IMG; i++) e = {e[IMG-2:0], mem[i]};
        return e;
    endfunction

    task automatic pulse_reload();
        @(negedge clk); #1 reload_req = 1'b1;
        @(negedge clk); #1 reload_req = 1'b0;
    endtask

    task automatic wait_chain();
        for (int k = 0; k < 800 && !(chain_done && cs_out); k++) @(negedge clk);
        repeat (12) @(negedge clk);
        #1;
    endtask

    task automatic slave_bit(input logic b, input logic s);
        @(negedge clk); #1 slv_din = b; sel_in = s; ext_cclk = 1'b0;
        @(negedge clk); #1 ext_cclk = 1'b1;
        @(negedge clk); #1 ext_cclk = 1'b0;
    endtask

    task automatic restart(input logic [2:0] m, input logic drive);
        @(negedge clk); #1 rst_n = 1'b0; mode_sel = m; mem_drive = drive;
        repeat (2) @(negedge clk);
        #1 rst_n = 1'b1; n_rise = 0; n_mrst = 0;
    endtask

    initial begin
        logic [IMG-1:0] sexp;
        int sn, r0;
        for (int i = 0; i < 64; i++) mem[i] = (i < IMG) ? (((i * 5 + 1) % 3) == 0) : 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk("R2 reset cfg_clk", cfg_clk, 0);
        chk("R2 reset mem_rst_n", mem_rst_n, 1);
        chk("R5 reset cs_out", cs_out, 0);
        chk("R4 reset own_done", own_done, 0);
        rst_n = 1'b1; n_rise = 0; n_mrst = 0;

        // master pass with a responsive downstream device
        wait_chain();
        chk("R1 auto start pulse", n_mrst, RST);
        chk("R4 image", cfg_image, exp_image());
        chk("R6 downstream bits not stored", cfg_image, exp_image());
        chk("R5 cs_out held", cs_out, 1);
        chk("R7 total rises", n_rise, IMG + SLV);
        r0 = n_rise;
        repeat (12) @(negedge clk);
        #1 chk("R7 clock stopped", n_rise, r0);

        // reload from DONE with new memory content; reload during load ignored
        for (int i = 0; i < IMG; i++) mem[i] = ((i * 3) % 7) < 3;
        n_rise = 0; n_mrst = 0;
        pulse_reload();
        for (int k = 0; k < 200 && n_rise < 4; k++) @(negedge clk);
        pulse_reload();
        wait_chain();
        chk("R9 image after reload", cfg_image, exp_image());
        chk("R9 single memrst pulse", n_mrst, RST);
        chk("R9 total rises", n_rise, IMG + SLV);

        // downstream never completes: watchdog
        slave_ok = 1'b0;
        pulse_reload();
        for (int k = 0; k < 800 && !wdog_fault; k++) @(negedge clk);
        #1 chk("R8 fault raised", wdog_fault, 1);
        r0 = n_rise;
        repeat (20) @(negedge clk);
        #1;
        chk("R8 clock frozen", n_rise, r0);
        chk("R8 cs dropped", cs_out, 0);

        // recovery from FAULT
        slave_ok = 1'b1;
        pulse_reload();
        wait_chain();
        chk("R9 fault cleared", wdog_fault, 0);
        chk("R9 done after recovery", own_done, 1);

        // slave serial, code 001
        restart(3'b001, 1'b0);
        sexp = '0; sn = 0;
        for (int i = 0; i < 16; i++) begin
            logic b, s;
            b = ((i * 7 + 2) % 5) < 2;
            s = !(i == 3 || i == 8 || i == 11);
            if (s && sn < IMG) begin sexp = {sexp[IMG-2:0], b}; sn++; end
            slave_bit(b, s);
        end
        repeat (3) @(negedge clk);
        #1;
        chk("R10 slave image", cfg_image, sexp);
        chk("R10 slave done", own_done, 1);
        chk("R10 no clock out", n_rise, 0);
        chk("R10 no memrst", n_mrst, 0);
        chk("R10 no cs_out", cs_out, 0);

        // slave serial, code 111, partial image
        restart(3'b111, 1'b0);
        sexp = '0;
        for (int i = 0; i < 5; i++) begin
            sexp = {sexp[IMG-2:0], 1'(i % 2)};
            slave_bit(1'(i % 2), 1'b1);
        end
        repeat (2) @(negedge clk);
        #1;
        chk("R10 partial image", cfg_image, sexp);
        chk("R10 partial not done", own_done, 0);

        // parallel codes stay idle
        restart(3'b010, 1'b0);
        for (int i = 0; i < 4; i++) slave_bit(1'b1, 1'b1);
        repeat (20) @(negedge clk);
        #1;
        chk("R11 idle no clock", n_rise, 0);
        chk("R11 idle no memrst", n_mrst, 0);
        chk("R11 idle image", cfg_image, 0);
        restart(3'b110, 1'b1);
        repeat (30) @(negedge clk);
        #1;
        chk("R11 code 110 no clock", n_rise, 0);
        chk("R11 code 110 no done", own_done, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule